// File: doc/BRIEF.md
# Accumulator ALU with Condition-Code Register

This block is the arithmetic and logic slice of a small accumulator machine. The sequencer supplies an operation code and a set of operands: the A accumulator, the B accumulator, a memory byte, the byte that follows it in memory, and a bit mask. In the same cycle the block returns an 8-bit result, a write strobe for that result, and the next value of the N, Z, V and C flags. A four-bit flag register inside the block holds the current flags. It loads the next flags on a clock edge only when the operation strobe is high.

Several operations only exist to set flags. Bit test and both compares compute a value, update the flags from it, and leave the write strobe low, so the sequencer never stores their result. Each operation fixes some flags to constants, computes others, and leaves the rest unchanged. The 16-bit compare treats A as the high byte and B as the low byte of a double accumulator. It subtracts a word whose high byte is the memory byte and whose low byte is the next memory byte.

Top module: `acc_alu_ccr`

## Requirements
- R1: The flag vector `flags_q` is ordered {N,Z,V,C} from bit 3 down to bit 0. While `rst_n` is low it reads 4'b0000.
- R2: Op code 0 (bit test) forms A AND memory byte. N is bit 7 of that value and Z is set when the value is zero. V becomes 0 and C keeps its current value. `result_we` stays 0.
- R3: Op code 1 (set bits) writes memory byte OR mask with `result_we`=1. N and Z follow the written value, V becomes 0 and C keeps its value.
- R4: Op code 2 (clear bits) writes memory byte AND NOT mask with `result_we`=1. Its flags follow the same rule as set bits.
- R5: Op code 3 (clear) writes 8'h00 with `result_we`=1 and gives flags N=0, Z=1, V=0, C=1'b0.
- R6: Op code 4 (complement) writes 8'hFF minus the memory byte with `result_we`=1. N and Z follow the result, V becomes 0 and C becomes 1.
- R7: Op code 5 (8-bit compare) evaluates A minus memory byte with `result_we`=0. C is the borrow, V is signed overflow, N is bit 7 of the difference and Z is set when the difference is zero.
- R8: Op code 6 (16-bit compare) evaluates {A,B} minus {memory byte, next byte} with `result_we`=0. The four flags follow the same rules as R7, but N comes from bit 15 and Z tests all 16 bits.
- R9: Op code 7 forces C to 0 and op code 8 forces V to 0. Both keep the other three flags and leave `result_we` at 0.
- R10: `flags_q` takes `flags_nxt` on a clock edge only when `op_valid` is 1. `result_we` is 0 whenever `op_valid` is 0. Op codes 9 to 15 leave every flag unchanged and never write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op_valid | input | 1 | Operation strobe; enables the write strobe and the flag load |
| op_sel | input | 4 | Operation code |
| acc_a | input | 8 | A accumulator (high byte of the double accumulator) |
| acc_b | input | 8 | B accumulator (low byte of the double accumulator) |
| mem_opnd | input | 8 | Memory operand byte (high byte of a 16-bit word) |
| mem_next | input | 8 | Following memory byte (low byte of a 16-bit word) |
| mask | input | 8 | Bit mask for set and clear bits |
| result | output | 8 | Computed value, valid to store when result_we is 1 |
| result_we | output | 1 | Write strobe for result |
| flags_nxt | output | 4 | Next {N,Z,V,C} for the present inputs |
| flags_q | output | 4 | Current registered {N,Z,V,C} |

## Verification
The compares run on equal operands to get Z, and on unsigned-lower operands to get the borrow. Operands whose signs differ show whether V is set exactly when the sign of the difference flips. A low byte that is zero while the high bytes differ proves that Z in the 16-bit compare looks at the whole word and not only one byte. Each flag-preserving operation runs after the flags have been driven to both polarities, so a flag that was kept can be told from one that was forced. Random operands and op codes follow, with the operation strobe dropped at times, including the unused codes and writer operations issued without the strobe.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_TEST  = 4'd0,
    OP_SETM  = 4'd1,
    OP_CLRM  = 4'd2,
    OP_ZERO  = 4'd3,
    OP_INV   = 4'd4,
    OP_CMP8  = 4'd5,
    OP_CMP16 = 4'd6,
    OP_CLC   = 4'd7,
    OP_CLV   = 4'd8
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  // Operations whose value is stored by the sequencer.
  function automatic logic op_writes(input logic [3:0] code);
    return (code == OP_SETM) || (code == OP_CLRM) ||
           (code == OP_ZERO) || (code == OP_INV);
  endfunction

  function automatic logic op_defined(input logic [3:0] code);
    return code <= OP_CLV;
  endfunction

  // Flag rule for logical results: N/Z from value, V cleared, C as given.
  function automatic ccr_t logic_flags(input logic msb, input logic zero,
                                       input logic carry);
    ccr_t f;
    f.n = msb;
    f.z = zero;
    f.v = 1'b0;
    f.c = carry;
    return f;
  endfunction

  function automatic ccr_t sub_flags(input logic msb, input logic zero,
                                     input logic ovf, input logic borrow);
    ccr_t f;
    f.n = msb;
    f.z = zero;
    f.v = ovf;
    f.c = borrow;
    return f;
  endfunction

endpackage

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] msk,
  output logic [W-1:0] lval,
  output logic         lmsb,
  output logic         lzero
);

  always_comb begin
    unique case (op)
      OP_TEST: lval = acc & opnd;
      OP_SETM: lval = opnd | msk;
      OP_CLRM: lval = opnd & ~msk;
      OP_INV:  lval = ~opnd;
      default: lval = '0;
    endcase
  end

  assign lmsb  = lval[W-1];
  assign lzero = ~|lval;

endmodule

// File: rtl/acc_alu_sub.sv
module acc_alu_sub #(
  parameter int W = 8
) (
  input  logic [W-1:0] minu,
  input  logic [W-1:0] subt,
  output logic [W-1:0] diff,
  output logic         borrow,
  output logic         ovf,
  output logic         dmsb,
  output logic         dzero
);

  logic [W:0] wide;

  assign wide   = {1'b0, minu} - {1'b0, subt};
  assign diff   = wide[W-1:0];
  assign borrow = wide[W];
  assign dmsb   = diff[W-1];
  assign dzero  = ~|diff;
  assign ovf    = (minu[W-1] ^ subt[W-1]) & (diff[W-1] ^ minu[W-1]);

endmodule

// File: rtl/acc_alu_ccr_reg.sv
module acc_alu_ccr_reg
  import acc_alu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  ccr_t d,
  output ccr_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/acc_alu_ccr.sv
module acc_alu_ccr
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_sel,
  input  logic [DATA_W-1:0] acc_a,
  input  logic [DATA_W-1:0] acc_b,
  input  logic [DATA_W-1:0] mem_opnd,
  input  logic [DATA_W-1:0] mem_next,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic [3:0]        flags_nxt,
  output logic [3:0]        flags_q
);

  localparam int WIDE_W = 2 * DATA_W;

  ccr_t cur, nxt;

  logic [DATA_W-1:0] lval;
  logic              lmsb, lzero;
  logic [DATA_W-1:0] d8;
  logic              b8, v8, n8, z8;
  logic [WIDE_W-1:0] d16;
  logic              b16, v16, n16, z16;
  logic              wr_op;
  logic              known_op;

  acc_alu_logic #(.W(DATA_W)) logic_i (
    .op(op_sel), .acc(acc_a), .opnd(mem_opnd), .msk(mask),
    .lval(lval), .lmsb(lmsb), .lzero(lzero)
  );

  acc_alu_sub #(.W(DATA_W)) sub8_i (
    .minu(acc_a), .subt(mem_opnd), .diff(d8),
    .borrow(b8), .ovf(v8), .dmsb(n8), .dzero(z8)
  );

  acc_alu_sub #(.W(WIDE_W)) sub16_i (
    .minu({acc_a, acc_b}), .subt({mem_opnd, mem_next}), .diff(d16),
    .borrow(b16), .ovf(v16), .dmsb(n16), .dzero(z16)
  );

  acc_alu_ccr_reg ccr_i (
    .clk(clk), .rst_n(rst_n), .load(op_valid), .d(nxt), .q(cur)
  );

  assign wr_op    = op_writes(op_sel);
  assign known_op = op_defined(op_sel);

  always_comb begin
    nxt = cur;
    unique case (op_sel)
      OP_TEST:  nxt = logic_flags(lmsb, lzero, cur.c);
      OP_SETM,
      OP_CLRM:  nxt = logic_flags(lmsb, lzero, cur.c);
      OP_ZERO:  nxt = logic_flags(1'b0, 1'b1, 1'b0);
      OP_INV:   nxt = logic_flags(lmsb, lzero, 1'b1);
      OP_CMP8:  nxt = sub_flags(n8, z8, v8, b8);
      OP_CMP16: nxt = sub_flags(n16, z16, v16, b16);
      OP_CLC:   nxt.c = 1'b0;
      OP_CLV:   nxt.v = 1'b0;
      default:  nxt = cur;
    endcase
  end

  always_comb begin
    unique case (op_sel)
      OP_CMP8:  result = d8;
      OP_CMP16: result = d16[DATA_W-1:0];
      default:  result = lval;
    endcase
  end

  assign result_we = op_valid & wr_op;
  assign flags_nxt = nxt;
  assign flags_q   = cur;

endmodule

// File: rtl/acc_alu_ccr_chk.sv
module acc_alu_ccr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [3:0]        op_sel,
  input logic [DATA_W-1:0] acc_a,
  input logic [DATA_W-1:0] mem_opnd,
  input logic [DATA_W-1:0] result,
  input logic              result_we,
  input logic [3:0]        flags_nxt,
  input logic [3:0]        flags_q,
  input logic              known_op
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> flags_q == 4'b0000);

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flags_q));

  // R10
  load_when_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> flags_q == $past(flags_nxt));

  // R10
  unknown_op_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !known_op |-> (flags_nxt == flags_q) && !result_we);

  // R2
  test_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 4'd0 |-> !result_we && flags_nxt[0] == flags_q[0] && !flags_nxt[1]);

  // R5
  clear_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 4'd3 |-> result == '0 && flags_nxt == 4'b0100);

  // R6
  invert_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 4'd4 |-> flags_nxt[0] && !flags_nxt[1] && (result ^ mem_opnd) == '1);

  // R7
  cmp8_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 4'd5 |-> flags_nxt[2] == (acc_a == mem_opnd) && !result_we);

  // R9
  clc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 4'd7 |-> flags_nxt == {flags_q[3:1], 1'b0});

  // R9
  clv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == 4'd8 |-> flags_nxt == {flags_q[3:2], 1'b0, flags_q[0]});

endmodule

bind acc_alu_ccr acc_alu_ccr_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
  .acc_a(acc_a), .mem_opnd(mem_opnd), .result(result),
  .result_we(result_we), .flags_nxt(flags_nxt), .flags_q(flags_q),
  .known_op(known_op)
);

// File: tb/acc_alu_ccr_tb_top.sv
module acc_alu_ccr_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_sel = 4'd15;
  logic [7:0] acc_a = '0, acc_b = '0, mem_opnd = '0, mem_next = '0, mask = '0;
  logic [7:0] result;
  logic       result_we;
  logic [3:0] flags_nxt, flags_q;

  int checks = 0;
  int errors = 0;
  logic [3:0] model_q = 4'b0000;

  always #10 clk = ~clk;

  acc_alu_ccr dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .acc_a(acc_a), .acc_b(acc_b), .mem_opnd(mem_opnd), .mem_next(mem_next),
    .mask(mask), .result(result), .result_we(result_we),
    .flags_nxt(flags_nxt), .flags_q(flags_q)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      7, 8: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Behavioural model: returns {value[7:0], write, N, Z, V, C}.
  function automatic logic [12:0] model(input int op, input int a, input int b,
      input int mo, input int mn, input int mk, input logic [3:0] q);
    int val = 0;
    int wr = 0;
    int n = q[3], z = q[2], v = q[1], c = q[0];
    int l, r, d, sl, sr;
    case (op)
      0: begin val = a & mo; n = val / 128; z = (val == 0); v = 0; end
      1: begin val = mo | mk; wr = 1; n = val / 128; z = (val == 0); v = 0; end
      2: begin val = mo & (255 - mk); wr = 1; n = val / 128; z = (val == 0); v = 0; end
      3: begin val = 0; wr = 1; n = 0; z = 1; v = 0; c = 0; end
      4: begin val = 255 - mo; wr = 1; n = val / 128; z = (val == 0); v = 0; c = 1; end
      5: begin
        d = (a - mo + 256) % 256;
        sl = (a > 127) ? a - 256 : a;
        sr = (mo > 127) ? mo - 256 : mo;
        n = d / 128; z = (d == 0); c = (a < mo);
        v = (sl - sr > 127) || (sl - sr < -128);
      end
      6: begin
        l = a * 256 + b; r = mo * 256 + mn;
        d = (l - r + 65536) % 65536;
        sl = (l > 32767) ? l - 65536 : l;
        sr = (r > 32767) ? r - 65536 : r;
        n = d / 32768; z = (d == 0); c = (l < r);
        v = (sl - sr > 32767) || (sl - sr < -32768);
      end
      7: c = 0;
      8: v = 0;
      default: ;
    endcase
    return {val[7:0], wr[0], n[0], z[0], v[0], c[0]};
  endfunction

  task automatic apply(input int op, input int a, input int b, input int mo,
                       input int mn, input int mk, input logic vld);
    logic [12:0] e;
    @(negedge clk);
    check("R10", "registered flags", int'(flags_q), int'(model_q));
    op_sel = op[3:0]; acc_a = a[7:0]; acc_b = b[7:0];
    mem_opnd = mo[7:0]; mem_next = mn[7:0]; mask = mk[7:0]; op_valid = vld;
    #2;
    e = model(op, a, b, mo, mn, mk, model_q);
    check(req_of(op), "next flags", int'(flags_nxt), int'(e[3:0]));
    check(vld ? req_of(op) : "R10", "write strobe", int'(result_we), vld ? int'(e[4]) : 0);
    if (e[4]) check(req_of(op), "result", int'(result), int'(e[12:5]));
    if (vld) model_q = e[3:0];
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "flags in reset", int'(flags_q), 0);
    rst_n = 1'b1;
    // R5 clear, then R6 complement sets C
    apply(3, 0, 0, 8'h5a, 0, 0, 1);
    apply(4, 0, 0, 8'h00, 0, 0, 1);
    apply(4, 0, 0, 8'hff, 0, 0, 1);
    // R2 bit test keeps C=1, zero and non-zero AND
    apply(0, 8'hf0, 0, 8'h0f, 0, 0, 1);
    apply(0, 8'h80, 0, 8'hc0, 0, 0, 1);
    // R3 and R4 with C set
    apply(1, 0, 0, 8'h01, 0, 8'h80, 1);
    apply(2, 0, 0, 8'h81, 0, 8'h81, 1);
    // R7 equal, lower, signed overflow both ways
    apply(5, 8'h42, 0, 8'h42, 0, 0, 1);
    apply(5, 8'h10, 0, 8'h20, 0, 0, 1);
    apply(5, 8'h80, 0, 8'h01, 0, 0, 1);
    apply(5, 8'h7f, 0, 8'hff, 0, 0, 1);
    // R9 clear-carry, clear-overflow, flags kept
    apply(7, 0, 0, 0, 0, 0, 1);
    apply(5, 8'h7f, 0, 8'hff, 0, 0, 1);
    apply(8, 0, 0, 0, 0, 0, 1);
    // R8 low byte equal but high differs, full equal, borrow, overflow
    apply(6, 8'h12, 8'h00, 8'h11, 8'h00, 0, 1);
    apply(6, 8'h12, 8'h34, 8'h12, 8'h34, 0, 1);
    apply(6, 8'h00, 8'h01, 8'h00, 8'h02, 0, 1);
    apply(6, 8'h80, 8'h00, 8'h00, 8'h01, 0, 1);
    // R10 no strobe, unused codes
    apply(3, 0, 0, 0, 0, 0, 0);
    apply(9, 0, 0, 0, 0, 0, 1);
    apply(15, 1, 2, 3, 4, 5, 1);
    for (int i = 0; i < 400; i++)
      apply($urandom_range(15), $urandom_range(255), $urandom_range(255),
            $urandom_range(255), $urandom_range(255), $urandom_range(255),
            ($urandom_range(3) != 0));
    @(negedge clk);
    check("R10", "final registered flags", int'(flags_q), int'(model_q));
    finish_run();
  end

endmodule